// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block is a real-time clock core. It keeps seconds, minutes, hours, weekday, day of month, month and a four-digit year, and it counts directly in packed BCD. A divider takes the system clock down to a sub-second step. A small sub-second counter counts those steps, and its wrap is the one-second tick that drives the calendar chain. Software reads the counters directly, with no BCD-to-binary conversion.

Software controls the core through a flat word-addressed register bus. The usual sequence to set the clock is: stop it, clear the prescaler, write the time fields, then set both the run and enable bits. A carry flag is set on every update of the seconds counter. Software clears the flag, reads the time fields, and then checks the flag again. If the flag is set again, a seconds update landed during the multi-register read, and software reads again. The same flag can raise an interrupt when its enable bit is set.

A write to the control word can also request a 30-second adjustment. This rounds the seconds to the nearest minute.

Top module: `rtcc_top`

## Requirements
- R1: After reset the clock reads 2000-01-01 00:00:00, with weekday 0 and a sub-second value of 0. Both control words read 0, and `carry_irq` is low.
- R2: The divider and the sub-second counter advance only when control B bit 0 (run) and bit 3 (enable) are both 1. The sub-second counter steps once every `PRESCALE_DIV` clocks. The seconds field advances once every `PRESCALE_DIV * 2**SUBSEC_W` running clocks.
- R3: Time fields are word addresses 1 to 7: seconds, minutes, hours, weekday, day, month, and a 16-bit year. They accept bus writes only while the run bit is 0. A write while running leaves the field unchanged.
- R4: Writing 1 to control B bit 1 clears the divider and the sub-second counter in the same cycle. The bit always reads back 0.
- R5: Seconds and minutes roll over from 59 to 00, and hours roll over from 23 to 00. Each rollover carries one step into the next field, with the BCD digit carry handled inside each field.
- R6: On a day carry, the weekday wraps from 6 to 0. The day of month wraps to 01 after the last day of the month. Month 12 wraps to 01 and advances the year. A year byte of 99 wraps to 00 and advances the century byte in bits 15:8.
- R7: February has 29 days when the year is a leap year, and 28 days otherwise. A year is a leap year when its low byte is divisible by 4. A low byte of 00 is a leap year only if the century byte is also divisible by 4.
- R8: Writing 1 to control B bit 2 sets the seconds to 00. If the seconds were 30 or more, the minutes advance with a full carry upward. The bit always reads back 0.
- R9: Control A bit 7 (carry flag) is set on every seconds update, whether from a tick or an adjustment. Writing 0 to it clears it, and writing 1 leaves it unchanged. A set and a clear in the same cycle leave it set.
- R10: `carry_irq` is high exactly when the carry flag and control A bit 4 (carry interrupt enable) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Word address: 0 sub-second, 1..7 time fields, 8 control A, 9 control B |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The bench builds the core with a divider of 2 and a 2-bit sub-second counter. With these values one second lasts 8 clocks. Month, year and century rollovers, the leap-year rule and 1999-to-2000 transitions are then each one loaded second away. With so short a second, the bench can place a carry-flag clear exactly on the edge of a tick, and it can read a partial sub-second count at a known value.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_SUBSEC = 4'd0;
    localparam logic [ADDR_W-1:0] A_SEC    = 4'd1;
    localparam logic [ADDR_W-1:0] A_MIN    = 4'd2;
    localparam logic [ADDR_W-1:0] A_HOUR   = 4'd3;
    localparam logic [ADDR_W-1:0] A_WDAY   = 4'd4;
    localparam logic [ADDR_W-1:0] A_MDAY   = 4'd5;
    localparam logic [ADDR_W-1:0] A_MON    = 4'd6;
    localparam logic [ADDR_W-1:0] A_YEAR   = 4'd7;
    localparam logic [ADDR_W-1:0] A_CTRLA  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CTRLB  = 4'd9;

    // control A bit positions
    localparam int unsigned CA_FLAG  = 7;
    localparam int unsigned CA_IE    = 4;
    // control B bit positions
    localparam int unsigned CB_EN    = 3;
    localparam int unsigned CB_ADJ   = 2;
    localparam int unsigned CB_PRST  = 1;
    localparam int unsigned CB_RUN   = 0;

    typedef struct packed {
        logic [15:0] year;
        logic [7:0]  mon;
        logic [7:0]  mday;
        logic [7:0]  wday;
        logic [7:0]  hour;
        logic [7:0]  min;
        logic [7:0]  sec;
    } cal_t;

    typedef struct packed {
        logic flag;
        logic cie;
        logic en;
        logic run;
    } ctl_t;

    localparam cal_t CAL_RESET = '{year: 16'h2000, mon: 8'h01, mday: 8'h01,
                                   wday: 8'h00, hour: 8'h00, min: 8'h00,
                                   sec: 8'h00};

    // add one to a two-digit packed BCD byte (caller handles the upper wrap)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // value of a BCD byte modulo 4 is (2*tens + ones) mod 4
    function automatic logic bcd_div4(input logic [7:0] v);
        logic [4:0] s;
        s = 5'(v[3:0]) + (v[4] ? 5'd2 : 5'd0);
        return s[1:0] == 2'd0;
    endfunction

    function automatic logic leap_year(input logic [15:0] y);
        return bcd_div4(y[7:0]) && ((y[7:0] != 8'h00) || bcd_div4(y[15:8]));
    endfunction

    // last day of a month, in BCD
    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtcc_prescaler.sv
module rtcc_prescaler #(
    parameter int unsigned DIV      = 256,
    parameter int unsigned SUBSEC_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                clr,
    output logic [SUBSEC_W-1:0] subsec,
    output logic                sec_tick
);

    localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic div_wrap;
    logic [SUBSEC_W-1:0] sub_d, sub_q;

    generate
        if (DIV == 1) begin : g_nodiv
            assign div_wrap = run;
        end else begin : g_div
            logic [DIV_W-1:0] div_d, div_q;

            always_comb begin
                div_d = div_q;
                if (clr)
                    div_d = '0;
                else if (run)
                    div_d = (div_q == DIV_W'(DIV - 1)) ? '0 : div_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end

            assign div_wrap = run && (div_q == DIV_W'(DIV - 1));
        end
    endgenerate

    always_comb begin
        sub_d = sub_q;
        if (clr)
            sub_d = '0;
        else if (div_wrap)
            sub_d = sub_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
    end

    assign subsec   = sub_q;
    assign sec_tick = div_wrap && !clr && (&sub_q);

endmodule

// File: rtl/rtcc_calendar.sv
module rtcc_calendar
    import rtcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              adjust,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output cal_t              cal
);

    cal_t cal_d, cal_q;
    logic min_inc, hr_inc, day_inc, mon_inc, yr_inc;

    always_comb begin
        cal_d   = cal_q;
        min_inc = 1'b0;
        hr_inc  = 1'b0;
        day_inc = 1'b0;
        mon_inc = 1'b0;
        yr_inc  = 1'b0;

        if (wr_en) begin
            case (wr_sel)
                A_SEC:   cal_d.sec  = wr_data[7:0];
                A_MIN:   cal_d.min  = wr_data[7:0];
                A_HOUR:  cal_d.hour = wr_data[7:0];
                A_WDAY:  cal_d.wday = wr_data[7:0];
                A_MDAY:  cal_d.mday = wr_data[7:0];
                A_MON:   cal_d.mon  = wr_data[7:0];
                A_YEAR:  cal_d.year = wr_data;
                default: ;
            endcase
        end else begin
            if (adjust) begin
                cal_d.sec = 8'h00;
                min_inc   = (cal_q.sec >= 8'h30);
            end else if (tick) begin
                if (cal_q.sec == 8'h59) begin
                    cal_d.sec = 8'h00;
                    min_inc   = 1'b1;
                end else begin
                    cal_d.sec = bcd_inc(cal_q.sec);
                end
            end

            if (min_inc) begin
                if (cal_q.min == 8'h59) begin
                    cal_d.min = 8'h00;
                    hr_inc    = 1'b1;
                end else begin
                    cal_d.min = bcd_inc(cal_q.min);
                end
            end

            if (hr_inc) begin
                if (cal_q.hour == 8'h23) begin
                    cal_d.hour = 8'h00;
                    day_inc    = 1'b1;
                end else begin
                    cal_d.hour = bcd_inc(cal_q.hour);
                end
            end

            if (day_inc) begin
                cal_d.wday = (cal_q.wday >= 8'h06) ? 8'h00 : cal_q.wday + 8'h01;
                if (cal_q.mday == last_day(cal_q.mon, leap_year(cal_q.year))) begin
                    cal_d.mday = 8'h01;
                    mon_inc    = 1'b1;
                end else begin
                    cal_d.mday = bcd_inc(cal_q.mday);
                end
            end

            if (mon_inc) begin
                if (cal_q.mon == 8'h12) begin
                    cal_d.mon = 8'h01;
                    yr_inc    = 1'b1;
                end else begin
                    cal_d.mon = bcd_inc(cal_q.mon);
                end
            end

            if (yr_inc) begin
                if (cal_q.year[7:0] == 8'h99) begin
                    cal_d.year[7:0]  = 8'h00;
                    cal_d.year[15:8] = (cal_q.year[15:8] == 8'h99) ? 8'h00
                                                                   : bcd_inc(cal_q.year[15:8]);
                end else begin
                    cal_d.year[7:0] = bcd_inc(cal_q.year[7:0]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= CAL_RESET;
        else        cal_q <= cal_d;
    end

    assign cal = cal_q;

endmodule

// File: rtl/rtcc_top.sv
module rtcc_top
    import rtcc_pkg::*;
#(
    parameter int unsigned PRESCALE_DIV = 256,
    parameter int unsigned SUBSEC_W     = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        carry_irq
);

    ctl_t ctl_d, ctl_q;
    cal_t cal;
    logic [SUBSEC_W-1:0] subsec;
    logic sec_tick, run, presc_clr, adj_req, time_wr, wr_a, wr_b;

    assign run = ctl_q.run && ctl_q.en;

    always_comb begin
        wr_a      = bus_wr && (bus_addr == A_CTRLA);
        wr_b      = bus_wr && (bus_addr == A_CTRLB);
        presc_clr = wr_b && bus_wdata[CB_PRST];
        adj_req   = wr_b && bus_wdata[CB_ADJ];
        time_wr   = bus_wr && !ctl_q.run && (bus_addr >= A_SEC) && (bus_addr <= A_YEAR);

        ctl_d = ctl_q;
        if (wr_a) begin
            ctl_d.cie = bus_wdata[CA_IE];
            if (!bus_wdata[CA_FLAG])
                ctl_d.flag = 1'b0;
        end
        if (wr_b) begin
            ctl_d.en  = bus_wdata[CB_EN];
            ctl_d.run = bus_wdata[CB_RUN];
        end
        if (sec_tick || adj_req)
            ctl_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rtcc_prescaler #(
        .DIV      (PRESCALE_DIV),
        .SUBSEC_W (SUBSEC_W)
    ) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clr      (presc_clr),
        .subsec   (subsec),
        .sec_tick (sec_tick)
    );

    rtcc_calendar cal_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .adjust  (adj_req),
        .wr_en   (time_wr),
        .wr_sel  (bus_addr),
        .wr_data (bus_wdata),
        .cal     (cal)
    );

    always_comb begin
        case (bus_addr)
            A_SUBSEC: bus_rdata = DATA_W'(subsec);
            A_SEC:    bus_rdata = {8'h00, cal.sec};
            A_MIN:    bus_rdata = {8'h00, cal.min};
            A_HOUR:   bus_rdata = {8'h00, cal.hour};
            A_WDAY:   bus_rdata = {8'h00, cal.wday};
            A_MDAY:   bus_rdata = {8'h00, cal.mday};
            A_MON:    bus_rdata = {8'h00, cal.mon};
            A_YEAR:   bus_rdata = cal.year;
            A_CTRLA:  bus_rdata = {8'h00, ctl_q.flag, 2'b00, ctl_q.cie, 4'b0000};
            A_CTRLB:  bus_rdata = {12'h000, ctl_q.en, 2'b00, ctl_q.run};
            default:  bus_rdata = '0;
        endcase
    end

    assign carry_irq = ctl_q.flag && ctl_q.cie;

endmodule

// File: rtl/rtcc_chk.sv
module rtcc_chk
    import rtcc_pkg::*;
#(
    parameter int unsigned SUBSEC_W = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run,
    input logic                started,
    input logic                presc_clr,
    input logic                adj_req,
    input logic                sec_tick,
    input logic [SUBSEC_W-1:0] subsec,
    input cal_t                cal,
    input logic                flag,
    input logic                cie,
    input logic                carry_irq
);

    assert_subsec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !presc_clr) |=> $stable(subsec));

    assert_locked_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !sec_tick && !adj_req) |=> $stable(cal));

    assert_presc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        presc_clr |=> (subsec == '0));

    assert_sec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cal.sec < 8'h60) && (cal.sec[3:0] < 4'd10));

    assert_wday_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal.wday <= 8'h06);

    assert_adjust_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adj_req |=> (cal.sec == 8'h00));

    assert_flag_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> flag);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cie |-> !carry_irq);

endmodule

bind rtcc_top rtcc_chk #(.SUBSEC_W(SUBSEC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .started   (ctl_q.run),
    .presc_clr (presc_clr),
    .adj_req   (adj_req),
    .sec_tick  (sec_tick),
    .subsec    (subsec),
    .cal       (cal),
    .flag      (ctl_q.flag),
    .cie       (ctl_q.cie),
    .carry_irq (carry_irq)
);

// File: tb/rtcc_top_tb_top.sv
`timescale 1ns/1ps
module rtcc_top_tb_top;

    localparam int unsigned DIV     = 2;
    localparam int unsigned SW      = 2;
    localparam int unsigned SEC_CYC = DIV * (2 ** SW);

    localparam logic [15:0] B_EN  = 16'h0008;
    localparam logic [15:0] B_ADJ = 16'h0004;
    localparam logic [15:0] B_RST = 16'h0002;
    localparam logic [15:0] B_RUN = 16'h0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        carry_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtcc_top #(.PRESCALE_DIV(DIV), .SUBSEC_W(SW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .carry_irq (carry_irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [3:0] a, input logic [15:0] exp);
        logic [15:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic load_time(input logic [15:0] y, input logic [7:0] mo, input logic [7:0] d,
                             input logic [7:0] wd, input logic [7:0] h, input logic [7:0] m,
                             input logic [7:0] s);
        bus_write(4'd9, B_EN);
        bus_write(4'd1, {8'h0, s});
        bus_write(4'd2, {8'h0, m});
        bus_write(4'd3, {8'h0, h});
        bus_write(4'd4, {8'h0, wd});
        bus_write(4'd5, {8'h0, d});
        bus_write(4'd6, {8'h0, mo});
        bus_write(4'd7, y);
    endtask

    // run exactly n seconds from a cleared prescaler, then stop
    task automatic go(input int n);
        bus_write(4'd9, B_EN | B_RST);
        bus_write(4'd9, B_EN | B_RUN);
        repeat (SEC_CYC * n) @(posedge clk);
        bus_write(4'd9, B_EN);
    endtask

    task automatic expect_cal(input string req, input logic [15:0] y, input logic [7:0] mo,
                              input logic [7:0] d, input logic [7:0] wd, input logic [7:0] h,
                              input logic [7:0] m, input logic [7:0] s);
        expect_reg(req, 4'd1, {8'h0, s});
        expect_reg(req, 4'd2, {8'h0, m});
        expect_reg(req, 4'd3, {8'h0, h});
        expect_reg(req, 4'd4, {8'h0, wd});
        expect_reg(req, 4'd5, {8'h0, d});
        expect_reg(req, 4'd6, {8'h0, mo});
        expect_reg(req, 4'd7, y);
    endtask

    task automatic t_reset();
        expect_cal("R1 reset time", 16'h2000, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
        expect_reg("R1 reset subsec", 4'd0, 16'h0);
        expect_reg("R1 reset ctrl A", 4'd8, 16'h0);
        expect_reg("R1 reset ctrl B", 4'd9, 16'h0);
        check("R1 reset irq", {15'h0, carry_irq}, 16'h0);
    endtask

    task automatic t_prescaler();
        load_time(16'h2023, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h20);
        bus_write(4'd9, B_EN | B_RST);
        bus_write(4'd9, B_EN | B_RUN);
        repeat (5) @(posedge clk);
        bus_write(4'd9, B_EN);   // six divider steps in total
        expect_reg("R2 subsec partial", 4'd0, 16'h3);
        expect_reg("R2 no second yet", 4'd1, 16'h20);
        bus_write(4'd9, B_EN | B_RST);
        expect_reg("R4 subsec cleared", 4'd0, 16'h0);
        expect_reg("R4 reset bit reads 0", 4'd9, B_EN);
        go(3);
        expect_reg("R2 three seconds", 4'd1, 16'h23);
    endtask

    task automatic t_enable_gate();
        load_time(16'h2023, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h40);
        bus_write(4'd9, B_RST);
        bus_write(4'd9, B_RUN);   // run without enable
        repeat (SEC_CYC * 3) @(posedge clk);
        expect_reg("R2 held without enable", 4'd1, 16'h40);
        expect_reg("R2 subsec held", 4'd0, 16'h0);
        bus_write(4'd9, 16'h0);
    endtask

    task automatic t_write_lock();
        load_time(16'h2023, 8'h05, 8'h10, 8'h03, 8'h08, 8'h00, 8'h10);
        expect_reg("R3 write while stopped", 4'd1, 16'h10);
        bus_write(4'd9, B_EN | B_RST);
        bus_write(4'd9, B_EN | B_RUN);
        bus_write(4'd1, 16'h44);
        bus_write(4'd7, 16'h1234);
        bus_write(4'd9, B_EN);
        expect_reg("R3 sec write ignored", 4'd1, 16'h10);
        expect_reg("R3 year write ignored", 4'd7, 16'h2023);
    endtask

    task automatic t_hms();
        load_time(16'h2023, 8'h03, 8'h15, 8'h02, 8'h12, 8'h34, 8'h56);
        go(1);
        expect_reg("R5 plain second", 4'd1, 16'h57);
        load_time(16'h2023, 8'h03, 8'h15, 8'h02, 8'h09, 8'h59, 8'h59);
        go(1);
        expect_cal("R5 hour digit carry", 16'h2023, 8'h03, 8'h15, 8'h02, 8'h10, 8'h00, 8'h00);
        load_time(16'h2023, 8'h03, 8'h15, 8'h03, 8'h23, 8'h59, 8'h59);
        go(1);
        expect_cal("R5 midnight", 16'h2023, 8'h03, 8'h16, 8'h04, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_dates();
        load_time(16'h1999, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
        go(1);
        expect_cal("R6 new year", 16'h2000, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
        load_time(16'h2024, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
        go(1);
        expect_cal("R6 30-day month", 16'h2024, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00);
        load_time(16'h9999, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        go(1);
        expect_reg("R6 century wrap", 4'd7, 16'h0000);
        load_time(16'h2024, 8'h01, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
        go(1);
        expect_reg("R6 jan end month", 4'd6, 16'h02);
        expect_reg("R6 jan end day", 4'd5, 16'h01);
    endtask

    task automatic t_leap();
        load_time(16'h2024, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        go(1);
        expect_reg("R7 2024 has feb 29", 4'd5, 16'h29);
        go(SEC_CYC * 0 + 0);
        load_time(16'h2024, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
        go(1);
        expect_reg("R7 after feb 29 month", 4'd6, 16'h03);
        expect_reg("R7 after feb 29 day", 4'd5, 16'h01);
        load_time(16'h2100, 8'h02, 8'h28, 8'h00, 8'h23, 8'h59, 8'h59);
        go(1);
        expect_reg("R7 2100 not leap", 4'd6, 16'h03);
        load_time(16'h2000, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
        go(1);
        expect_reg("R7 2000 leap", 4'd5, 16'h29);
        load_time(16'h2023, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        go(1);
        expect_reg("R7 2023 not leap", 4'd6, 16'h03);
    endtask

    task automatic t_adjust();
        bus_write(4'd8, 16'h0000);
        load_time(16'h2023, 8'h07, 8'h04, 8'h02, 8'h10, 8'h59, 8'h45);
        bus_write(4'd9, B_EN | B_ADJ);
        expect_cal("R8 round up", 16'h2023, 8'h07, 8'h04, 8'h02, 8'h11, 8'h00, 8'h00);
        expect_reg("R8 adjust bit reads 0", 4'd9, B_EN);
        expect_reg("R9 adjust sets flag", 4'd8, 16'h0080);
        load_time(16'h2023, 8'h07, 8'h04, 8'h02, 8'h10, 8'h20, 8'h29);
        bus_write(4'd9, B_EN | B_ADJ);
        expect_reg("R8 round down sec", 4'd1, 16'h00);
        expect_reg("R8 round down min", 4'd2, 16'h20);
    endtask

    task automatic t_carry();
        load_time(16'h2023, 8'h07, 8'h04, 8'h02, 8'h10, 8'h00, 8'h00);
        bus_write(4'd8, 16'h0000);
        expect_reg("R9 cleared by 0", 4'd8, 16'h0000);
        go(1);
        expect_reg("R9 set by tick", 4'd8, 16'h0080);
        bus_write(4'd8, 16'h0080);
        expect_reg("R9 write 1 keeps", 4'd8, 16'h0080);
        bus_write(4'd8, 16'h0000);
        expect_reg("R9 write 0 clears", 4'd8, 16'h0000);
        // clear lands on the tick edge: set wins
        bus_write(4'd9, B_EN | B_RST);
        bus_write(4'd9, B_EN | B_RUN);
        repeat (SEC_CYC - 1) @(posedge clk);
        bus_write(4'd8, 16'h0000);
        bus_write(4'd9, B_EN);
        expect_reg("R9 set wins over clear", 4'd8, 16'h0080);
        expect_reg("R9 tick counted", 4'd1, 16'h02);
    endtask

    task automatic t_irq();
        bus_write(4'd9, B_EN | B_ADJ);
        check("R10 masked", {15'h0, carry_irq}, 16'h0);
        bus_write(4'd8, 16'h0090);
        #1 check("R10 raised", {15'h0, carry_irq}, 16'h1);
        bus_write(4'd8, 16'h0010);
        #1 check("R10 dropped on clear", {15'h0, carry_irq}, 16'h0);
        bus_write(4'd9, B_EN | B_ADJ);
        #1 check("R10 raised by adjust", {15'h0, carry_irq}, 16'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prescaler();
        t_enable_gate();
        t_write_lock();
        t_hms();
        t_dates();
        t_leap();
        t_adjust();
        t_carry();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule